// File: doc/BRIEF.md
# DRAM Row Boundary Decoder

This block takes a physical memory address and works out which of up to eight DRAM rows holds it. A row is a 64-bit data slice, or 72 bits when eight ECC bits are included. Each row has a programmable boundary register. Boundary N holds the cumulative top of rows 0 through N, counted in 8 MB units, and the values never decrease from one row to the next. The decoder compares the upper address bits against every boundary in parallel. It picks the lowest-numbered row whose boundary lies above the address. It then drives a one-hot row index and pulls both active-low chip selects of that row's pair low.

A mode input sets the memory type. With SDRAM all eight rows can be used. With EDO only rows 0 to 5 can be used, so rows 6 and 7 are never selected. An address that no usable row covers raises an out-of-range flag, and in that case no chip select is asserted.

The request side has a valid strobe and no ready signal. The decoder takes one request in every cycle that has the strobe, so it never applies back-pressure. The result appears one clock later with its own valid bit, and nothing stalls it. The boundary registers are programmed elsewhere and reach this block as plain inputs.

Top module: `dram_row_select`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all sixteen chip selects are high and `row_hit` is zero. `addr_oor` and `rsp_valid` are also zero.
- R2: `rsp_valid` equals the value `req_valid` had at the previous rising clock edge. All result outputs belong to the request from that edge.
- R3: The row chosen is the lowest index i whose boundary `row_bound[8*i+7:8*i]` is greater than `req_addr[31:23]`. The comparison is unsigned.
- R4: A row whose boundary equals the boundary of the row below it is empty and is never selected. For row 0, "the row below" means a boundary of zero.
- R5: Selecting row i drives `cs_n[2*i]` and `cs_n[2*i+1]` low and holds every other chip select high. `row_hit` bit i is the only bit set.
- R6: When `mem_edo` is 1, rows 6 and 7 are never selected. An address that falls into their range is reported as out of range.
- R7: When no usable row's boundary exceeds the address's upper bits, `addr_oor` is 1, all chip selects are high and `row_hit` is zero.
- R8: One cycle after a clock edge where `req_valid` was 0, all chip selects are high and `row_hit` and `addr_oor` are zero.
- R9: At most one bit of `row_hit` is set at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_addr | input | 32 | Physical byte address |
| row_bound | input | 64 | Eight 8-bit cumulative boundaries in 8 MB units; row i at bits [8i+7:8i] |
| mem_edo | input | 1 | 1 = EDO (rows 0-5 usable), 0 = SDRAM (rows 0-7) |
| rsp_valid | output | 1 | Result of the previous cycle's request is present |
| row_hit | output | 8 | One-hot selected row |
| cs_n | output | 16 | Active-low chip selects, pair i at bits 2i and 2i+1 |
| addr_oor | output | 1 | Address lies beyond all usable rows |

## Verification
A wrong internal state shows on the ports as soon as the next request completes, one clock after it is taken. A bad comparator or priority term picks a neighbouring row, which shows as the wrong pair of `cs_n`. It can also leave a gap that falsely raises `addr_oor`. If the chip-select register and the row register drift apart, the two halves of a pair, or `row_hit` and `cs_n`, disagree within that same cycle. Stale state after an idle cycle shows up as chip selects that stay low with `rsp_valid` at zero.

// File: rtl/drs_pkg.sv
package drs_pkg;
  localparam int unsigned DRS_ROWS      = 8;
  localparam int unsigned DRS_EDO_ROWS  = 6;
  localparam int unsigned DRS_ADDR_W    = 32;
  localparam int unsigned DRS_BOUND_W   = 8;
  localparam int unsigned DRS_GRAN_LOG2 = 23;

  typedef enum logic {
    MEM_SDRAM = 1'b0,
    MEM_EDO   = 1'b1
  } mem_kind_e;

  function automatic int unsigned drs_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/drs_bound_cmp.sv
module drs_bound_cmp #(
  parameter int unsigned ROWS    = drs_pkg::DRS_ROWS,
  parameter int unsigned BOUND_W = drs_pkg::DRS_BOUND_W,
  parameter int unsigned UP_W    = drs_pkg::DRS_ADDR_W - drs_pkg::DRS_GRAN_LOG2
) (
  input  logic [UP_W-1:0]         upper,
  input  logic [ROWS*BOUND_W-1:0] bounds,
  output logic [ROWS-1:0]         below
);
  localparam int unsigned CMP_W = drs_pkg::drs_max(UP_W, BOUND_W);

  logic [CMP_W-1:0] up_ext;
  assign up_ext = CMP_W'(upper);

  for (genvar i = 0; i < ROWS; i++) begin : g_cmp
    logic [CMP_W-1:0] b_ext;
    assign b_ext    = CMP_W'(bounds[i*BOUND_W +: BOUND_W]);
    assign below[i] = (up_ext < b_ext);
  end
endmodule

// File: rtl/drs_first_row.sv
module drs_first_row #(
  parameter int unsigned ROWS     = drs_pkg::DRS_ROWS,
  parameter int unsigned EDO_ROWS = drs_pkg::DRS_EDO_ROWS
) (
  input  logic [ROWS-1:0] below,
  input  drs_pkg::mem_kind_e kind,
  output logic [ROWS-1:0] sel,
  output logic            none
);
  logic [ROWS-1:0] usable;

  for (genvar i = 0; i < ROWS; i++) begin : g_pick
    if (i >= EDO_ROWS) begin : g_limited
      assign usable[i] = (kind == drs_pkg::MEM_SDRAM);
    end else begin : g_always
      assign usable[i] = 1'b1;
    end
    if (i == 0) begin : g_first
      assign sel[i] = below[i] & usable[i];
    end else begin : g_rest
      assign sel[i] = below[i] & ~below[i-1] & usable[i];
    end
  end

  assign none = ~|sel;
endmodule

// File: rtl/drs_cs_pairs.sv
module drs_cs_pairs #(
  parameter int unsigned ROWS = drs_pkg::DRS_ROWS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [ROWS-1:0]   sel,
  output logic [2*ROWS-1:0] cs_n
);
  for (genvar i = 0; i < ROWS; i++) begin : g_pair
    logic act;
    assign act = take & sel[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cs_n[2*i +: 2] <= 2'b11;
      else        cs_n[2*i +: 2] <= {2{~act}};
    end
  end
endmodule

// File: rtl/dram_row_select.sv
module dram_row_select #(
  parameter int unsigned ROWS      = drs_pkg::DRS_ROWS,
  parameter int unsigned EDO_ROWS  = drs_pkg::DRS_EDO_ROWS,
  parameter int unsigned ADDR_W    = drs_pkg::DRS_ADDR_W,
  parameter int unsigned BOUND_W   = drs_pkg::DRS_BOUND_W,
  parameter int unsigned GRAN_LOG2 = drs_pkg::DRS_GRAN_LOG2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [ROWS*BOUND_W-1:0] row_bound,
  input  logic                    mem_edo,
  output logic                    rsp_valid,
  output logic [ROWS-1:0]         row_hit,
  output logic [2*ROWS-1:0]       cs_n,
  output logic                    addr_oor
);
  localparam int unsigned UP_W = ADDR_W - GRAN_LOG2;

  drs_pkg::mem_kind_e kind;
  logic [UP_W-1:0]    upper;
  logic [ROWS-1:0]    below;
  logic [ROWS-1:0]    sel;
  logic               none;

  assign kind  = mem_edo ? drs_pkg::MEM_EDO : drs_pkg::MEM_SDRAM;
  assign upper = req_addr[ADDR_W-1:GRAN_LOG2];

  drs_bound_cmp #(.ROWS(ROWS), .BOUND_W(BOUND_W), .UP_W(UP_W)) u_cmp (
    .upper (upper),
    .bounds(row_bound),
    .below (below)
  );

  drs_first_row #(.ROWS(ROWS), .EDO_ROWS(EDO_ROWS)) u_pick (
    .below(below),
    .kind (kind),
    .sel  (sel),
    .none (none)
  );

  drs_cs_pairs #(.ROWS(ROWS)) u_cs (
    .clk  (clk),
    .rst_n(rst_n),
    .take (req_valid),
    .sel  (sel),
    .cs_n (cs_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      row_hit   <= '0;
      addr_oor  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      row_hit   <= req_valid ? sel : '0;
      addr_oor  <= req_valid & none;
    end
  end

  AST_ONE_ROW: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(row_hit)); // R9
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid == $past(req_valid)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> (&cs_n && row_hit == '0 && !addr_oor)); // R8
  AST_OOR_NO_CS: assert property (@(posedge clk) disable iff (!rst_n) addr_oor |-> (&cs_n && row_hit == '0)); // R7
  AST_EDO_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) mem_edo |=> row_hit[ROWS-1:EDO_ROWS] == '0); // R6

  for (genvar i = 0; i < ROWS; i++) begin : g_chk
    AST_PAIR_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n[2*i] == ~row_hit[i]) && (cs_n[2*i+1] == ~row_hit[i])); // R5
  end
endmodule

// File: tb/dram_row_select_tb.sv
module dram_row_select_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [63:0] row_bound = '0;
  logic        mem_edo = 1'b0;
  logic        rsp_valid;
  logic [7:0]  row_hit;
  logic [15:0] cs_n;
  logic        addr_oor;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dram_row_select u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .row_bound(row_bound), .mem_edo(mem_edo), .rsp_valid(rsp_valid),
    .row_hit(row_hit), .cs_n(cs_n), .addr_oor(addr_oor)
  );

  // expected row index, -1 when out of range (R3, R4, R6, R7)
  function automatic int exp_row(input logic [31:0] a, input logic [63:0] b, input logic edo);
    int lim;
    lim = edo ? 6 : 8;
    for (int i = 0; i < lim; i++) begin
      if ({1'b0, b[i*8 +: 8]} > a[31:23]) return i;
    end
    return -1;
  endfunction

  function automatic logic [15:0] exp_cs(input int r);
    logic [15:0] c;
    c = 16'hFFFF;
    if (r >= 0) begin
      c[2*r] = 1'b0;
      c[2*r+1] = 1'b0;
    end
    return c;
  endfunction

  task automatic check(input string req, input logic v, input int r);
    logic [7:0] eh;
    logic       eo;
    eh = (v && r >= 0) ? 8'(1 << r) : 8'h00;
    eo = v && (r < 0);
    n_vec++;
    if (rsp_valid !== v || row_hit !== eh || cs_n !== (v ? exp_cs(r) : 16'hFFFF) || addr_oor !== eo) begin
      n_bad++;
      $display("FAIL %s: got vld=%b hit=%h cs=%h oor=%b exp vld=%b hit=%h cs=%h oor=%b",
               req, rsp_valid, row_hit, cs_n, addr_oor, v, eh, v ? exp_cs(r) : 16'hFFFF, eo);
    end
  endtask

  task automatic apply(input string req, input logic v, input logic [31:0] a);
    int r;
    req_valid = v;
    req_addr  = a;
    r = exp_row(a, row_bound, mem_edo);
    @(negedge clk);
    check(req, v, r);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : stim
    logic [31:0] seed;
    seed = $urandom(32'h5EED_1234);
    repeat (3) @(negedge clk);
    n_vec++;
    if (cs_n !== 16'hFFFF || row_hit !== 8'h00 || addr_oor !== 1'b0 || rsp_valid !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: got cs=%h hit=%h oor=%b vld=%b exp FFFF 00 0 0", cs_n, row_hit, addr_oor, rsp_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b0, -1);

    // boundaries: 2,2(empty),5,9,9(empty),12,20,30 in 8MB units
    row_bound = {8'd30, 8'd20, 8'd12, 8'd9, 8'd9, 8'd5, 8'd2, 8'd2};
    mem_edo = 1'b0;
    apply("R3", 1'b1, 32'h0000_0000);
    apply("R3", 1'b1, {9'd1, 23'h7FFFFF});
    apply("R4", 1'b1, {9'd2, 23'd0});        // row 1 empty -> row 2
    apply("R4", 1'b1, {9'd8, 23'd5});        // row 4 empty -> row 3
    apply("R4", 1'b1, {9'd9, 23'd0});        // -> row 5
    apply("R5", 1'b1, {9'd29, 23'd0});       // row 7
    apply("R7", 1'b1, {9'd30, 23'd0});
    apply("R7", 1'b1, 32'hFFFF_FFFF);
    apply("R8", 1'b0, {9'd3, 23'd0});
    apply("R2", 1'b1, {9'd13, 23'd0});       // row 6
    mem_edo = 1'b1;
    apply("R6", 1'b1, {9'd13, 23'd0});       // row 6 range -> oor
    apply("R6", 1'b1, {9'd11, 23'd0});       // row 5 still usable
    apply("R6", 1'b1, {9'd25, 23'd0});
    row_bound = '0;
    apply("R4", 1'b1, 32'h0);                // all empty -> oor
    mem_edo = 1'b0;

    for (int k = 0; k < 2000; k++) begin
      logic [63:0] b;
      int acc;
      acc = 0;
      for (int i = 0; i < 8; i++) begin
        if ($urandom_range(0, 3) != 0) acc += $urandom_range(1, 40);
        if (acc > 255) acc = 255;
        b[i*8 +: 8] = 8'(acc);
      end
      row_bound = b;
      mem_edo = ($urandom_range(0, 2) == 0);
      apply("R3", ($urandom_range(0, 5) != 0), {9'($urandom_range(0, 300)), 23'($urandom)});
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule